// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the access address for each beat of a short burst. A load cycle captures a full external address. Its two low bits become the burst starting point, and the access address appears on the outputs one clock later as beat 0. Each later continue cycle steps an internal beat counter. The low address bits then follow either a linear wrap-around order or an interleaved order, chosen by a static order-select input. The upper address bits stay as loaded.

After four accesses the burst wraps back to its starting point. Continuing past that repeats the same four-beat pattern. Loading on every cycle gives plain single accesses, so bursting is optional for the user. A clock-enable input freezes the whole block when low. All outputs come from flops, and a synchronous active-high reset clears them.

Top module: `burst_agen`

## Requirements
- R1: While reset is high, at the next clock edge `acc_addr` becomes 0 and `beat_idx` becomes 0.
- R2: A clock edge with `clk_en`=1 and `step`=0 loads the address: one edge later `acc_addr` equals the `addr_in` applied at that edge, and `beat_idx` is 0.
- R3: A clock edge with `clk_en`=1 and `step`=1 advances the burst: `beat_idx` becomes (previous `beat_idx` + 1) mod 4.
- R4: During advance edges, the bits of `acc_addr` above bit 1 stay unchanged.
- R5: With `order_sel`=0 (linear), the low two bits of `acc_addr` equal (start + `beat_idx`) mod 4. Here start is bits [1:0] of the loaded address. For example, start 2 gives 2,3,0,1.
- R6: With `order_sel`=1 (interleaved), the low two bits of `acc_addr` equal start XOR `beat_idx`. For example, start 1 gives 1,0,3,2.
- R7: The advance edge after beat 3 returns `beat_idx` to 0 and the low bits to the start value. Further advances repeat the same four-beat pattern.
- R8: A clock edge with `clk_en`=0 leaves `acc_addr` and `beat_idx` unchanged, whatever `step` and `addr_in` are.
- R9: Loading on consecutive edges gives single accesses: each loaded address appears unchanged on `acc_addr` with `beat_idx`=0 one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low freezes all state |
| step | input | 1 | 0 = load new address, 1 = advance to next beat |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W (20) | External address for load cycles |
| acc_addr | output | ADDR_W (20) | Registered effective access address |
| beat_idx | output | CNT_W (2) | Registered beat number within the burst |

## Verification
The order-invariance assertions assume that `order_sel` only changes together with a load, never on an advance edge. They also assume that `step`, `clk_en` and `addr_in` carry known values once reset has been released. The bench drives `order_sel` only inside the same cycle as a load, and it drives every input on the falling edge. Each start value is walked through all beats and the wrap in both orders. Freeze cycles and back-to-back loads are placed in the middle of a burst.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_agen_beat_ctr.sv
module burst_agen_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             load,
  input  logic [CNT_W-1:0] addr_low,
  output logic [CNT_W-1:0] start_nx,
  output logic [CNT_W-1:0] beat_nx
);
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;

  always_comb begin
    start_nx = load ? addr_low : start_q;
    beat_nx  = load ? '0 : CNT_W'(beat_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (clk_en) begin
      start_q <= start_nx;
      beat_q  <= beat_nx;
    end
  end

  // R7: after the last beat the counter restarts and the start value is kept
  p_wrap_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load && beat_q == LAST_BEAT) |=> (beat_q == '0 && $stable(start_q)));
endmodule

// File: rtl/burst_agen_seq_map.sv
module burst_agen_seq_map
  import burst_agen_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             order_sel,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;
  order_e           order;

  assign order   = order_e'(order_sel);
  assign lin_low = CNT_W'(start + beat);

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
    assign ilv_low[b] = start[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVE: low = ilv_low;
      default:          low = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_agen_out_reg.sv
module burst_agen_out_reg #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic                    load,
  input  logic [ADDR_W-CNT_W-1:0] upper_in,
  input  logic [CNT_W-1:0]        low_nx,
  input  logic [CNT_W-1:0]        beat_nx,
  output logic [ADDR_W-1:0]       acc_addr,
  output logic [CNT_W-1:0]        beat_idx
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [UP_W-1:0] upper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q  <= '0;
      acc_addr <= '0;
      beat_idx <= '0;
    end else if (clk_en) begin
      if (load) upper_q <= upper_in;
      acc_addr <= {(load ? upper_in : upper_q), low_nx};
      beat_idx <= beat_nx;
    end
  end

  // R4: upper bits of the output agree with the held upper register
  p_upper_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> (acc_addr[ADDR_W-1:CNT_W] == upper_q));
endmodule

// File: rtl/burst_agen.sv
module burst_agen
  import burst_agen_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              step,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [CNT_W-1:0]  beat_idx
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic             load;
  logic [CNT_W-1:0] start_nx;
  logic [CNT_W-1:0] beat_nx;
  logic [CNT_W-1:0] low_nx;

  assign load = !step;

  burst_agen_beat_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .load     (load),
    .addr_low (addr_in[CNT_W-1:0]),
    .start_nx (start_nx),
    .beat_nx  (beat_nx)
  );

  burst_agen_seq_map #(.CNT_W(CNT_W)) map_i (
    .order_sel (order_sel),
    .start     (start_nx),
    .beat      (beat_nx),
    .low       (low_nx)
  );

  burst_agen_out_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) oreg_i (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .load     (load),
    .upper_in (addr_in[ADDR_W-1:CNT_W]),
    .low_nx   (low_nx),
    .beat_nx  (beat_nx),
    .acc_addr (acc_addr),
    .beat_idx (beat_idx)
  );

  // Derived start points seen at the outputs, one per order
  logic [CNT_W-1:0] acc_low;
  logic [CNT_W-1:0] lin_origin;
  logic [CNT_W-1:0] ilv_origin;
  assign acc_low    = acc_addr[CNT_W-1:0];
  assign lin_origin = CNT_W'(acc_low - beat_idx);
  assign ilv_origin = acc_low ^ beat_idx;

  // R2, R9: a load shows the address with beat zero one edge later
  p_load_visible_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !step) |=> (acc_addr == $past(addr_in) && beat_idx == '0));

  // R3: advance increments the beat number modulo the burst length
  p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step) |=> (beat_idx == CNT_W'($past(beat_idx) + 1'b1)));

  // R4: upper bits do not move while advancing
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step) |=> $stable(acc_addr[ADDR_W-1:UP_W-UP_W+CNT_W]));

  // R5: linear order keeps (low - beat) fixed across advances
  p_linear_origin_r5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step && order_sel == ORDER_LINEAR) |=> $stable(lin_origin));

  // R6: interleaved order keeps (low xor beat) fixed across advances
  p_ilv_origin_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && step && order_sel == ORDER_INTERLEAVE) |=> $stable(ilv_origin));

  // R8: frozen clock enable holds every output
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(acc_addr) && $stable(beat_idx)));
endmodule

// File: tb/burst_agen_tb_top.sv
module burst_agen_tb_top;
  localparam int AW = 20;
  localparam int CW = 2;
  localparam int UW = AW - CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic          step = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] acc_addr;
  logic [CW-1:0] beat_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_agen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .step      (step),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .acc_addr  (acc_addr),
    .beat_idx  (beat_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, return just after the next rising edge
  task automatic drive(input logic ce, input logic st, input logic [AW-1:0] a, input logic m);
    @(negedge clk);
    clk_en = ce; step = st; addr_in = a; order_sel = m;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [CW-1:0] exp_low(input logic m, input logic [CW-1:0] s,
                                            input logic [CW-1:0] b);
    return m ? (s ^ b) : CW'(s + b);
  endfunction

  task automatic t_reset();
    repeat (3) drive(1'b1, 1'b0, 20'hABCDE, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset addr", 32'(acc_addr), 32'h0);
    check("R1 reset beat", 32'(beat_idx), 32'h0);
  endtask

  task automatic t_all_starts(input logic m);
    for (int s = 0; s < 4; s++) begin
      logic [UW-1:0] up;
      up = UW'(32'h2A5C3 + s * 32'h111);
      drive(1'b1, 1'b0, {up, CW'(s)}, m);
      check("R2 load addr", 32'(acc_addr), 32'({up, CW'(s)}));
      check("R2 load beat", 32'(beat_idx), 32'h0);
      for (int b = 1; b < 4; b++) begin
        drive(1'b1, 1'b1, 20'h0F0F0, m);
        check("R3 beat", 32'(beat_idx), 32'(b));
        check("R4 upper", 32'(acc_addr[AW-1:CW]), 32'(up));
        if (m) check("R6 ilv low", 32'(acc_addr[CW-1:0]), 32'(exp_low(m, CW'(s), CW'(b))));
        else   check("R5 lin low", 32'(acc_addr[CW-1:0]), 32'(exp_low(m, CW'(s), CW'(b))));
      end
      drive(1'b1, 1'b1, 20'h0F0F0, m);
      check("R7 wrap beat", 32'(beat_idx), 32'h0);
      check("R7 wrap addr", 32'(acc_addr), 32'({up, CW'(s)}));
    end
  endtask

  task automatic t_long_run();
    drive(1'b1, 1'b0, 20'h40003, 1'b1);
    for (int k = 1; k <= 10; k++) begin
      drive(1'b1, 1'b1, 20'h00000, 1'b1);
      check("R7 repeat", 32'(acc_addr), 32'({18'h10000, CW'(3) ^ CW'(k)}));
    end
  endtask

  task automatic t_freeze();
    drive(1'b1, 1'b0, 20'h12341, 1'b0);
    drive(1'b1, 1'b1, 20'h00000, 1'b0);
    check("R5 pre-freeze", 32'(acc_addr), 32'h12342);
    drive(1'b0, 1'b0, 20'hFFFFC, 1'b0);
    check("R8 ignore load addr", 32'(acc_addr), 32'h12342);
    check("R8 ignore load beat", 32'(beat_idx), 32'h1);
    drive(1'b0, 1'b1, 20'hFFFFC, 1'b0);
    check("R8 ignore step", 32'(beat_idx), 32'h1);
    drive(1'b1, 1'b1, 20'h00000, 1'b0);
    check("R8 resume addr", 32'(acc_addr), 32'h12343);
    check("R8 resume beat", 32'(beat_idx), 32'h2);
  endtask

  task automatic t_single();
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      a = AW'(32'h3C00 * k + 32'h91 + k);
      drive(1'b1, 1'b0, a, k[0]);
      check("R9 single addr", 32'(acc_addr), 32'(a));
      check("R9 single beat", 32'(beat_idx), 32'h0);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_all_starts(1'b0);
    t_all_starts(1'b1);
    t_long_run();
    t_freeze();
    t_single();
    report();
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end
endmodule